// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column addresses of one synchronous DRAM burst. A controller pulses `start` together with the start column and the burst settings. From the next cycle on, the block presents one column per beat on `col`, qualified by `valid`. It moves to the next beat on each clock where `advance` is high, so a clock-suspend cycle keeps the current beat on the outputs. `last` marks the final beat of a fixed-length burst. `terminate` cuts any burst short.

The burst length code `blen_code` selects the length:

| Code | Burst |
|------|-------|
| 0 | 1 beat |
| 1 | 2 beats |
| 2 | 4 beats |
| 3 | 8 beats |
| 7 | full page |
| 4, 5, 6 | reserved |

Fixed lengths stay inside their aligned block of columns, in either linear (sequential) or XOR (interleaved) order. A full-page burst walks the whole row, wraps from the top column back to zero, and runs until it is terminated. A single-write mode flag makes every write a one-beat access, while reads keep the programmed length. The row, the bank, the command timing and the data path are handled elsewhere.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, `valid`, `last` and `cfg_err` are all 0.
- R2: A `start` pulse makes `valid` 1 in the next cycle, with `col` equal to the sampled `start_col` (beat 0).
- R3: While a burst is active, a cycle with `advance` low (and no `start` or `terminate`) keeps `col` and `valid` unchanged.
- R4: With `interleave`=0, codes 0, 1, 2 and 3 give bursts of 1, 2, 4 and 8 beats. Beat i has low bits (start + i) mod L. The column bits above the burst block never change.
- R5: With `interleave`=1 and codes 1 to 3, beat i is the start column with its low log2(L) bits XORed with i.
- R6: `last` is 1 exactly on the final beat of a fixed-length burst. Once that beat is accepted with `advance` high, `valid` is 0 in the next cycle.
- R7: Code 7 is a full-page burst. It is sequential, wraps from column 2^COL_W-1 to column 0, and never raises `last`.
- R8: `terminate` high during an active burst makes `valid` 0 in the next cycle, whatever the level of `advance`.
- R9: With `single_write`=1, a burst started with `is_write`=1 is one beat long. A burst started with `is_write`=0 keeps the programmed length and order.
- R10: Codes 4, 5 and 6 give a one-beat burst with `cfg_err`=1. Code 7 with `interleave`=1 sets `cfg_err`=1 and runs in sequential order. `cfg_err` holds until the next `start`, which reloads it.
- R11: A `start` during an active burst abandons that burst and begins the new one at its beat 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a burst with the settings sampled this cycle |
| start_col | input | COL_W | First column of the burst |
| blen_code | input | 3 | Burst length code (0..3 = 1/2/4/8, 7 = full page, 4..6 reserved) |
| interleave | input | 1 | 1 = interleaved order, 0 = sequential order |
| single_write | input | 1 | 1 = writes are one beat long |
| is_write | input | 1 | 1 = the burst being started is a write |
| advance | input | 1 | Consume the current beat on this clock |
| terminate | input | 1 | End the active burst at this clock |
| col | output | COL_W | Column of the current beat |
| valid | output | 1 | A beat is being presented |
| last | output | 1 | The current beat is the final one of a fixed-length burst |
| cfg_err | output | 1 | The settings of the latest burst were illegal |

## Verification
The table-driven walk uses start columns in the middle and at the top of their aligned block. This separates a correct wrap inside the block from a carry into the upper column bits. The same start column is run in sequential and in interleaved order, which tells a linear walk apart from an XOR walk. The single-write cases pair a write and a read with identical settings, so that only the read/write flag differs between them. The directed tests cover the following:
- A full page crossing the top column.
- Suspended beats.
- Termination with and without `advance`.
- A restart in mid-burst.
- The illegal settings and the clearing of `cfg_err`.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;
  localparam int unsigned ARITH_W = 16;
  localparam logic [2:0] BLC_PAGE = 3'd7;

  function automatic logic code_reserved(input logic [2:0] code);
    return (code == 3'd4) || (code == 3'd5) || (code == 3'd6);
  endfunction

  // Column of a beat: bits outside mask come from base, bits inside walk.
  function automatic logic [ARITH_W-1:0] beat_addr(
    input logic [ARITH_W-1:0] base,
    input logic [ARITH_W-1:0] idx,
    input logic [ARITH_W-1:0] mask,
    input logic               ilv);
    logic [ARITH_W-1:0] walk;
    walk = ilv ? (base ^ idx) : (base + idx);
    return (base & ~mask) | (walk & mask);
  endfunction
endpackage

// File: rtl/burst_cfg_decode.sv
module burst_cfg_decode
  import burst_col_pkg::*;
#(
  parameter int unsigned COL_W = 9
) (
  input  logic [2:0]       blen_code,
  input  logic             interleave,
  input  logic             single_write,
  input  logic             is_write,
  output logic [COL_W-1:0] blk_mask,
  output logic             page_mode,
  output logic             ilv_eff,
  output logic             bad_cfg
);
  logic reserved;
  logic page_code;

  assign reserved  = code_reserved(blen_code);
  assign page_code = (blen_code == BLC_PAGE);

  always_comb begin
    bad_cfg   = reserved || (page_code && interleave);
    page_mode = 1'b0;
    ilv_eff   = interleave;
    blk_mask  = '0;
    if (single_write && is_write) begin
      blk_mask = '0;
    end else if (page_code) begin
      page_mode = 1'b1;
      blk_mask  = '1;
      ilv_eff   = 1'b0;
    end else if (!reserved) begin
      blk_mask = COL_W'((32'd1 << blen_code) - 32'd1);
    end
  end
endmodule

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl #(
  parameter int unsigned COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             advance,
  input  logic             terminate,
  input  logic [COL_W-1:0] start_col,
  input  logic [COL_W-1:0] d_mask,
  input  logic             d_page,
  input  logic             d_ilv,
  input  logic             d_err,
  output logic             active,
  output logic [COL_W-1:0] beat_cnt,
  output logic [COL_W-1:0] base_col,
  output logic [COL_W-1:0] blk_mask,
  output logic             page_mode,
  output logic             ilv_mode,
  output logic             err_q,
  output logic             final_beat
);
  assign final_beat = active && !page_mode && (beat_cnt == blk_mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active    <= 1'b0;
      beat_cnt  <= '0;
      base_col  <= '0;
      blk_mask  <= '0;
      page_mode <= 1'b0;
      ilv_mode  <= 1'b0;
      err_q     <= 1'b0;
    end else if (start) begin
      active    <= 1'b1;
      beat_cnt  <= '0;
      base_col  <= start_col;
      blk_mask  <= d_mask;
      page_mode <= d_page;
      ilv_mode  <= d_ilv;
      err_q     <= d_err;
    end else if (active) begin
      if (terminate) begin
        active <= 1'b0;
      end else if (advance) begin
        if (final_beat) active <= 1'b0;
        else            beat_cnt <= beat_cnt + COL_W'(1);
      end
    end
  end
endmodule

// File: rtl/burst_addr_map.sv
module burst_addr_map
  import burst_col_pkg::*;
#(
  parameter int unsigned COL_W = 9
) (
  input  logic [COL_W-1:0] base_col,
  input  logic [COL_W-1:0] beat_cnt,
  input  logic [COL_W-1:0] blk_mask,
  input  logic             ilv_mode,
  output logic [COL_W-1:0] col
);
  logic [ARITH_W-1:0] wide;
  assign wide = beat_addr(ARITH_W'(base_col), ARITH_W'(beat_cnt),
                          ARITH_W'(blk_mask), ilv_mode);
  assign col  = wide[COL_W-1:0];
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
  parameter int unsigned COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic [2:0]       blen_code,
  input  logic             interleave,
  input  logic             single_write,
  input  logic             is_write,
  input  logic             advance,
  input  logic             terminate,
  output logic [COL_W-1:0] col,
  output logic             valid,
  output logic             last,
  output logic             cfg_err
);
  logic [COL_W-1:0] d_mask;
  logic             d_page, d_ilv, d_err;
  logic             active, page_mode, ilv_mode, err_q, final_beat;
  logic [COL_W-1:0] beat_cnt, base_col, blk_mask;

  burst_cfg_decode #(.COL_W(COL_W)) u_dec (
    .blen_code(blen_code), .interleave(interleave),
    .single_write(single_write), .is_write(is_write),
    .blk_mask(d_mask), .page_mode(d_page), .ilv_eff(d_ilv), .bad_cfg(d_err));

  burst_seq_ctrl #(.COL_W(COL_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .start(start), .advance(advance),
    .terminate(terminate), .start_col(start_col),
    .d_mask(d_mask), .d_page(d_page), .d_ilv(d_ilv), .d_err(d_err),
    .active(active), .beat_cnt(beat_cnt), .base_col(base_col),
    .blk_mask(blk_mask), .page_mode(page_mode), .ilv_mode(ilv_mode),
    .err_q(err_q), .final_beat(final_beat));

  burst_addr_map #(.COL_W(COL_W)) u_map (
    .base_col(base_col), .beat_cnt(beat_cnt), .blk_mask(blk_mask),
    .ilv_mode(ilv_mode), .col(col));

  assign valid   = active;
  assign last    = final_beat;
  assign cfg_err = err_q;
endmodule

// File: rtl/burst_col_gen_chk.sv
module burst_col_gen_chk #(
  parameter int unsigned COL_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [COL_W-1:0] start_col,
  input logic [2:0]       blen_code,
  input logic             single_write,
  input logic             is_write,
  input logic             advance,
  input logic             terminate,
  input logic [COL_W-1:0] col,
  input logic             valid,
  input logic             last,
  input logic             cfg_err,
  input logic [COL_W-1:0] blk_mask,
  input logic             page_mode
);
  p_start_beat0_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> valid && (col == $past(start_col)));

  p_suspend_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !advance && !start && !terminate |=> valid && $stable(col));

  p_block_upper_r4: assert property (@(posedge clk) disable iff (!rst_n)
    valid && advance && !last && !terminate && !start && !page_mode
    |=> ((col ^ $past(col)) & ~$past(blk_mask)) == '0);

  p_last_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
    valid && last && advance && !start |=> !valid);

  p_page_no_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    page_mode && valid |-> !last);

  p_term_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
    valid && terminate && !start |=> !valid);

  p_single_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start && single_write && is_write |=> last);

  p_reserved_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start && (blen_code inside {3'd4, 3'd5, 3'd6}) |=> cfg_err && last);
endmodule

bind burst_col_gen burst_col_gen_chk #(.COL_W(COL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
  .blen_code(blen_code), .single_write(single_write), .is_write(is_write),
  .advance(advance), .terminate(terminate), .col(col), .valid(valid),
  .last(last), .cfg_err(cfg_err), .blk_mask(blk_mask), .page_mode(page_mode));

// File: tb/burst_col_gen_test.sv
`timescale 1ns/1ps
module burst_col_gen_test;
  localparam int COL_W = 9;
  localparam int NCOL  = 512;

  typedef struct packed {
    logic [8:0] sc;
    logic [2:0] code;
    logic       ilv;
    logic       swm;
    logic       wr;
    logic [3:0] nb;
    logic       err;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{9'h005, 3'd0, 1'b0, 1'b0, 1'b0, 4'd1, 1'b0},
    '{9'h00B, 3'd1, 1'b0, 1'b0, 1'b0, 4'd2, 1'b0},
    '{9'h0D6, 3'd2, 1'b0, 1'b0, 1'b0, 4'd4, 1'b0},
    '{9'h1FD, 3'd3, 1'b0, 1'b0, 1'b0, 4'd8, 1'b0},
    '{9'h0D5, 3'd2, 1'b1, 1'b0, 1'b0, 4'd4, 1'b0},
    '{9'h013, 3'd3, 1'b1, 1'b0, 1'b0, 4'd8, 1'b0},
    '{9'h013, 3'd3, 1'b0, 1'b1, 1'b1, 4'd1, 1'b0},
    '{9'h013, 3'd3, 1'b0, 1'b1, 1'b0, 4'd8, 1'b0},
    '{9'h040, 3'd5, 1'b0, 1'b0, 1'b0, 4'd1, 1'b1},
    '{9'h022, 3'd2, 1'b0, 1'b0, 1'b1, 4'd4, 1'b0}
  };

  logic clk = 0, rst_n = 0, start = 0, interleave = 0, single_write = 0;
  logic is_write = 0, advance = 0, terminate = 0;
  logic [COL_W-1:0] start_col = '0;
  logic [2:0] blen_code = '0;
  logic [COL_W-1:0] col;
  logic valid, last, cfg_err;
  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  burst_col_gen #(.COL_W(COL_W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
    .blen_code(blen_code), .interleave(interleave), .single_write(single_write),
    .is_write(is_write), .advance(advance), .terminate(terminate),
    .col(col), .valid(valid), .last(last), .cfg_err(cfg_err));

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Expected column from the requirement text: block of length len.
  function automatic int exp_col(input int sc, input int i, input int len,
                                 input bit ilv, input bit page);
    int blk, off;
    if (page) return (sc + i) % NCOL;
    blk = sc - (sc % len);
    off = sc % len;
    if (ilv) return blk + (off ^ (i % len));
    return blk + ((off + i) % len);
  endfunction

  task automatic do_start(input int sc, input int code, input bit ilv,
                          input bit swm, input bit wr);
    start_col = COL_W'(sc); blen_code = 3'(code); interleave = ilv;
    single_write = swm; is_write = wr; start = 1;
    @(negedge clk);
    start = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 valid after reset", valid, 0);
    chk("R1 last after reset", last, 0);
    chk("R1 cfg_err after reset", cfg_err, 0);
    rst_n = 1;
    advance = 1;
    @(negedge clk);

    // Table walk
    for (int v = 0; v < NV; v++) begin
      string tag;
      tag = VECS[v].err ? "R10" : (VECS[v].swm ? "R9" : (VECS[v].ilv ? "R5" : "R4"));
      do_start(VECS[v].sc, VECS[v].code, VECS[v].ilv, VECS[v].swm, VECS[v].wr);
      chk({tag, " cfg_err"}, cfg_err, VECS[v].err);
      for (int i = 0; i < VECS[v].nb; i++) begin
        chk(i == 0 ? "R2 beat0 col" : {tag, " col"}, col,
            exp_col(VECS[v].sc, i, VECS[v].nb, VECS[v].ilv, 1'b0));
        chk("R2 valid in burst", valid, 1);
        chk("R6 last flag", last, (i == VECS[v].nb - 1) ? 1 : 0);
        @(negedge clk);
      end
      chk("R6 idle after final beat", valid, 0);
    end

    // R3: suspended beats hold
    do_start(9'h010, 3, 0, 0, 0);
    advance = 0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R3 hold col", col, 9'h010);
      chk("R3 hold valid", valid, 1);
    end
    advance = 1;
    @(negedge clk);
    chk("R3 resume col", col, 9'h011);
    terminate = 1;
    @(negedge clk);
    terminate = 0;

    // R7: full page wraps over the top column; R8 terminate with advance low
    do_start(9'h1FE, 7, 0, 0, 0);
    for (int i = 0; i < 4; i++) begin
      chk("R7 page col", col, exp_col(9'h1FE, i, NCOL, 0, 1));
      chk("R7 page no last", last, 0);
      if (i < 3) @(negedge clk);
    end
    advance = 0; terminate = 1;
    @(negedge clk);
    terminate = 0; advance = 1;
    chk("R8 terminate without advance", valid, 0);

    // R8: terminate with advance high mid burst
    do_start(9'h060, 3, 0, 0, 0);
    @(negedge clk);
    chk("R8 mid burst col", col, 9'h061);
    terminate = 1;
    @(negedge clk);
    terminate = 0;
    chk("R8 terminate with advance", valid, 0);

    // R11: restart during a burst
    do_start(9'h030, 3, 0, 0, 0);
    @(negedge clk);
    chk("R11 first burst col", col, 9'h031);
    do_start(9'h055, 1, 0, 0, 0);
    chk("R11 restart col", col, 9'h055);
    @(negedge clk);
    chk("R11 restart second col", col, 9'h054);
    chk("R11 restart last", last, 1);
    @(negedge clk);
    chk("R11 restart ends", valid, 0);

    // R10: page with interleave runs sequential with error
    do_start(9'h0F5, 7, 1, 0, 0);
    chk("R10 page+ilv err", cfg_err, 1);
    chk("R10 page+ilv col0", col, 9'h0F5);
    @(negedge clk);
    chk("R10 page+ilv sequential", col, 9'h0F6);
    terminate = 1;
    @(negedge clk);
    terminate = 0;
    chk("R10 err held after end", cfg_err, 1);
    do_start(9'h000, 0, 0, 0, 0);
    chk("R10 err cleared by good start", cfg_err, 0);
    chk("R10 good single beat last", last, 1);
    @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule